// File: doc/BRIEF.md
# Next Instruction Pointer Branch Unit

This block owns the 32-bit instruction pointer of a small processor and computes its next value every cycle. The decoder presents the kind of control transfer for the current instruction, the byte length of that instruction, a signed 8-bit displacement, a register operand and the three condition flags zero, sign and overflow. The unit returns the pointer the machine will fetch from next, says whether a jump was taken, and loads the new pointer when the step enable is high. It is the only path by which the pointer changes.

Relative jumps are two bytes long, so their target is measured from the byte after the jump. Conditional jumps that fail fall through by those two bytes. A halt instruction parks the pointer on itself and raises a sticky halted status that only reset removes. All address arithmetic wraps modulo 2^32. The reset input is asynchronous and active low; its release is synchronised internally, so the block leaves reset on the second rising clock edge after the input goes high.

Top module: `nip_branch_unit`

## Requirements
- R1: After reset the pointer is 0x00000000, halted is 0, and with kind 0 the taken output is 0.
- R2: Kind 1 (relative jump) gives next pointer = pointer + 2 + sign-extended displacement, modulo 2^32, with taken = 1.
- R3: A conditional kind (2, 3 or 4) whose condition fails gives next pointer = pointer + 2 and taken = 0.
- R4: Kind 2 (jump if equal) is taken exactly when flags bit 0 (zero) is 1.
- R5: Kind 3 (jump if greater) is taken exactly when flags bit 0 (zero) is 0 and flags bit 1 (sign) equals flags bit 2 (overflow).
- R6: Kind 4 (jump if less) is taken exactly when flags bit 1 (sign) differs from flags bit 2 (overflow).
- R7: Kind 5 (register jump) gives next pointer = reg_value unchanged, with taken = 1.
- R8: Kind 0 (sequential) and the spare kind 7 give next pointer = pointer + ilen (zero-extended) and taken = 0.
- R9: Kind 6 (halt) gives next pointer = current pointer and taken = 0; once stepped, halted is 1, the pointer stays fixed and later steps of any kind have no effect until reset.
- R10: On a rising clock edge with step high the pointer takes the next-pointer value; with step low it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Load the next pointer at this edge |
| kind | input | 3 | Control transfer kind (codes in R2 to R9) |
| ilen | input | 3 | Byte length of a sequential instruction |
| disp | input | 8 | Signed displacement for relative jumps |
| reg_value | input | 32 | Target for register jumps |
| flags | input | 3 | bit 0 zero, bit 1 sign, bit 2 overflow |
| ip | output | 32 | Current instruction pointer |
| next_ip | output | 32 | Pointer that the next step will load |
| taken | output | 1 | A jump is taken this cycle |
| halted | output | 1 | Sticky halt status |

## Verification
The bench sweeps every non-halt kind over all eight flag combinations and displacements of -128, -1, 0 and +127, so a greater/less condition built from the wrong flag pair, or a zero-extended displacement, shows as a wrong target or a wrong taken bit. Wrap-around cases at the top and bottom of the address space catch an adder that drops the carry boundary incorrectly, and a fall-through that uses the instruction length instead of 2 shows on failed conditions. Halt is checked for staying on its own address, and for ignoring a later relative jump; a design whose halt is not sticky would move the pointer there.

// File: rtl/nip_pkg.sv
package nip_pkg;
  typedef enum logic [2:0] {
    BK_SEQ  = 3'd0,
    BK_REL  = 3'd1,
    BK_EQ   = 3'd2,
    BK_GT   = 3'd3,
    BK_LT   = 3'd4,
    BK_REG  = 3'd5,
    BK_HALT = 3'd6,
    BK_SPARE = 3'd7
  } br_kind_e;

  typedef enum logic [2:0] {
    TS_HOLD, TS_SEQ, TS_FALL, TS_REL, TS_REG
  } tgt_sel_e;

  localparam int FLAG_W = 3;
  localparam int FL_ZF  = 0;
  localparam int FL_SF  = 1;
  localparam int FL_OF  = 2;
  localparam int JUMP_LEN = 2;
endpackage

// File: rtl/nip_rst_sync.sv
module nip_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/nip_cond.sv
module nip_cond
  import nip_pkg::*;
(
  input  logic [2:0]        kind,
  input  logic [FLAG_W-1:0] flags,
  input  logic              halted,
  output tgt_sel_e          sel,
  output logic              jump
);
  logic zf, sf, ovf, met, is_cond;
  br_kind_e k;

  always_comb begin
    k   = br_kind_e'(kind);
    zf  = flags[FL_ZF];
    sf  = flags[FL_SF];
    ovf = flags[FL_OF];
    met     = 1'b0;
    is_cond = 1'b0;
    case (k)
      BK_EQ: begin is_cond = 1'b1; met = zf; end
      BK_GT: begin is_cond = 1'b1; met = !zf && (sf == ovf); end
      BK_LT: begin is_cond = 1'b1; met = (sf != ovf); end
      default: ;
    endcase

    sel  = TS_SEQ;
    jump = 1'b0;
    if (halted || k == BK_HALT) begin
      sel = TS_HOLD;
    end else if (k == BK_REL) begin
      sel = TS_REL; jump = 1'b1;
    end else if (k == BK_REG) begin
      sel = TS_REG; jump = 1'b1;
    end else if (is_cond) begin
      sel  = met ? TS_REL : TS_FALL;
      jump = met;
    end
  end

  // R3: a failed condition never reports a jump
  always_comb begin
    if (is_cond && !met && !halted)
      p_fail_not_taken_r3: assert (!jump && sel == TS_FALL);
  end
endmodule

// File: rtl/nip_target.sv
module nip_target
  import nip_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic [AW-1:0] ip,
  input  logic [LW-1:0] ilen,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] reg_value,
  input  tgt_sel_e      sel,
  output logic [AW-1:0] next_ip
);
  localparam logic [AW-1:0] STEP2 = AW'(JUMP_LEN);

  logic [AW-1:0] disp_ext, fall_addr, rel_addr, seq_addr;

  always_comb begin
    disp_ext  = {{(AW-DW){disp[DW-1]}}, disp};
    fall_addr = ip + STEP2;
    rel_addr  = fall_addr + disp_ext;
    seq_addr  = ip + {{(AW-LW){1'b0}}, ilen};
    case (sel)
      TS_HOLD: next_ip = ip;
      TS_FALL: next_ip = fall_addr;
      TS_REL:  next_ip = rel_addr;
      TS_REG:  next_ip = reg_value;
      default: next_ip = seq_addr;
    endcase
  end
endmodule

// File: rtl/nip_state.sv
module nip_state #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          halt_req,
  input  logic [AW-1:0] next_ip,
  output logic [AW-1:0] ip_q,
  output logic          halted_q
);
  logic [AW-1:0] ip_d;
  logic          halted_d;
  logic          load_en;

  always_comb begin
    load_en  = step && !halted_q;
    ip_d     = load_en ? next_ip : ip_q;
    halted_d = halted_q || (load_en && halt_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      ip_q     <= ip_d;
      halted_q <= halted_d;
    end
  end

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> halted_q);
  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> $stable(ip_q));
  p_hold_no_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ip_q));
endmodule

// File: rtl/nip_branch_unit.sv
module nip_branch_unit
  import nip_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 8,
  parameter int LW = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [2:0]        kind,
  input  logic [LW-1:0]     ilen,
  input  logic [DW-1:0]     disp,
  input  logic [AW-1:0]     reg_value,
  input  logic [FLAG_W-1:0] flags,
  output logic [AW-1:0]     ip,
  output logic [AW-1:0]     next_ip,
  output logic              taken,
  output logic              halted
);
  localparam logic [AW-1:0] STEP2 = AW'(JUMP_LEN);

  logic     rst_sync_n;
  tgt_sel_e sel;
  logic     jump;
  logic     halt_req;

  nip_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  nip_cond u_cond (
    .kind(kind), .flags(flags), .halted(halted), .sel(sel), .jump(jump)
  );

  nip_target #(.AW(AW), .DW(DW), .LW(LW)) u_tgt (
    .ip(ip), .ilen(ilen), .disp(disp), .reg_value(reg_value),
    .sel(sel), .next_ip(next_ip)
  );

  assign halt_req = (kind == BK_HALT);
  assign taken    = jump;

  nip_state #(.AW(AW)) u_state (
    .clk(clk), .rst_n(rst_sync_n), .step(step), .halt_req(halt_req),
    .next_ip(next_ip), .ip_q(ip), .halted_q(halted)
  );

  p_rel_target_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step && !halted && kind == BK_REL) |=>
      ip == $past(ip + STEP2 + {{(AW-DW){disp[DW-1]}}, disp}));
  p_reg_load_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step && !halted && kind == BK_REG) |=> ip == $past(reg_value));
  p_seq_adv_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step && !halted && kind == BK_SEQ) |=>
      ip == $past(ip + {{(AW-LW){1'b0}}, ilen}));
  p_halt_enter_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step && kind == BK_HALT) |=> (halted && $stable(ip)));
  p_halt_no_take_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halted |-> !taken);
endmodule

// File: tb/test_nip_branch_unit.sv
`timescale 1ns/1ps
module test_nip_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step;
  logic [2:0]  kind;
  logic [2:0]  ilen;
  logic [7:0]  disp;
  logic [31:0] reg_value;
  logic [2:0]  flags;
  logic [31:0] ip, next_ip;
  logic        taken, halted;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] m_ip;
  logic        m_halt;

  always #4 clk = ~clk;

  nip_branch_unit i_nip_branch_unit (
    .clk(clk), .rst_n(rst_n), .step(step), .kind(kind), .ilen(ilen),
    .disp(disp), .reg_value(reg_value), .flags(flags), .ip(ip),
    .next_ip(next_ip), .taken(taken), .halted(halted)
  );

  typedef struct packed {
    logic [31:0] start;
    logic [2:0]  k;
    logic [2:0]  f;
    logic [7:0]  d;
    logic [2:0]  len;
    logic [31:0] rv;
    logic [31:0] exp_ip;
    logic        exp_tk;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h28, 3'd1, 3'b000, 8'hF4, 3'd2, 32'h0, 32'h1E, 1'b1},          // R2
    '{32'h28, 3'd2, 3'b001, 8'h08, 3'd2, 32'h0, 32'h32, 1'b1},          // R4
    '{32'h28, 3'd3, 3'b110, 8'hF4, 3'd2, 32'h0, 32'h1E, 1'b1},          // R5
    '{32'h28, 3'd4, 3'b010, 8'h04, 3'd2, 32'h0, 32'h2E, 1'b1},          // R6
    '{32'h10, 3'd2, 3'b000, 8'h7F, 3'd2, 32'h0, 32'h12, 1'b0},          // R3
    '{32'h50, 3'd0, 3'b000, 8'h00, 3'd3, 32'h0, 32'h53, 1'b0},          // R8
    '{32'h10, 3'd0, 3'b111, 8'h00, 3'd5, 32'h0, 32'h15, 1'b0},          // R8
    '{32'h28, 3'd5, 3'b000, 8'h00, 3'd2, 32'h1E, 32'h1E, 1'b1},         // R7
    '{32'hFFFFFFFF, 3'd1, 3'b000, 8'h01, 3'd2, 32'h0, 32'h2, 1'b1},     // R2 wrap
    '{32'h1, 3'd1, 3'b000, 8'h80, 3'd2, 32'h0, 32'hFFFFFF83, 1'b1},     // R2 wrap down
    '{32'h40, 3'd7, 3'b101, 8'h33, 3'd1, 32'h0, 32'h41, 1'b0},          // R8 spare kind
    '{32'h30, 3'd3, 3'b111, 8'h10, 3'd2, 32'h0, 32'h32, 1'b0}           // R3/R5
  };

  function automatic logic m_taken(input logic [2:0] k, input logic [2:0] f, input logic h);
    if (h) return 1'b0;
    case (k)
      3'd1, 3'd5: return 1'b1;
      3'd2: return f[0];
      3'd3: return !f[0] && (f[1] == f[2]);
      3'd4: return f[1] != f[2];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_next(input logic [31:0] p, input logic [2:0] k,
      input logic [2:0] f, input logic [7:0] d, input logic [2:0] len,
      input logic [31:0] rv, input logic h);
    logic [31:0] dx;
    dx = {{24{d[7]}}, d};
    if (h || k == 3'd6) return p;
    case (k)
      3'd1: return p + 32'd2 + dx;
      3'd2, 3'd3, 3'd4: return m_taken(k, f, h) ? p + 32'd2 + dx : p + 32'd2;
      3'd5: return rv;
      default: return p + {29'd0, len};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drives one instruction, checks the combinational outputs, steps and checks the pointer
  task automatic run_op(input string req, input logic [2:0] k, input logic [2:0] f,
      input logic [7:0] d, input logic [2:0] len, input logic [31:0] rv, input logic st);
    logic [31:0] en;
    logic et;
    @(negedge clk);
    kind = k; flags = f; disp = d; ilen = len; reg_value = rv; step = st;
    #1;
    en = m_next(m_ip, k, f, d, len, rv, m_halt);
    et = m_taken(k, f, m_halt);
    chk({req, " next_ip"}, next_ip, en);
    chk({req, " taken"}, {31'd0, taken}, {31'd0, et});
    @(posedge clk);
    if (st && !m_halt) begin
      m_ip = en;
      if (k == 3'd6) m_halt = 1'b1;
    end
    #1;
    chk({req, " ip"}, ip, m_ip);
    chk({req, " halted"}, {31'd0, halted}, {31'd0, m_halt});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step = 1'b0; kind = 3'd0; ilen = 3'd1; disp = 8'd0;
    reg_value = 32'd0; flags = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    m_ip = 32'd0; m_halt = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] dvals [4];
    dvals[0] = 8'h80; dvals[1] = 8'hFF; dvals[2] = 8'h00; dvals[3] = 8'h7F;

    do_reset();
    @(negedge clk); #1;
    chk("R1 reset ip", ip, 32'd0);
    chk("R1 reset halted", {31'd0, halted}, 32'd0);
    chk("R1 reset taken", {31'd0, taken}, 32'd0);

    // table of hand-computed vectors
    for (int i = 0; i < NV; i++) begin
      run_op("R7 preload", 3'd5, 3'd0, 8'd0, 3'd1, VECS[i].start, 1'b1);
      @(negedge clk);
      kind = VECS[i].k; flags = VECS[i].f; disp = VECS[i].d;
      ilen = VECS[i].len; reg_value = VECS[i].rv; step = 1'b1;
      #1;
      chk("R2-table next_ip", next_ip, VECS[i].exp_ip);
      chk("R3-table taken", {31'd0, taken}, {31'd0, VECS[i].exp_tk});
      @(posedge clk); #1;
      chk("R10 table ip", ip, VECS[i].exp_ip);
      m_ip = VECS[i].exp_ip;
    end

    // sweep: kinds x flags x displacements (R2..R8)
    for (int k = 0; k < 6; k++) begin
      for (int f = 0; f < 8; f++) begin
        for (int di = 0; di < 4; di++) begin
          run_op("R7 base", 3'd5, 3'd0, 8'd0, 3'd1, 32'h0000_1000, 1'b1);
          case (k)
            1: run_op("R2 sweep", 3'(k), 3'(f), dvals[di], 3'd3, 32'hDEAD0000, 1'b1);
            2: run_op("R4 sweep", 3'(k), 3'(f), dvals[di], 3'd3, 32'hDEAD0000, 1'b1);
            3: run_op("R5 sweep", 3'(k), 3'(f), dvals[di], 3'd3, 32'hDEAD0000, 1'b1);
            4: run_op("R6 sweep", 3'(k), 3'(f), dvals[di], 3'd3, 32'hDEAD0000, 1'b1);
            5: run_op("R7 sweep", 3'(k), 3'(f), dvals[di], 3'd3, 32'hDEAD0000, 1'b1);
            default: run_op("R8 sweep", 3'(k), 3'(f), dvals[di], 3'd3, 32'hDEAD0000, 1'b1);
          endcase
        end
      end
    end

    // step low holds the pointer
    run_op("R7 base", 3'd5, 3'd0, 8'd0, 3'd1, 32'h0000_0200, 1'b1);
    run_op("R10 no step", 3'd1, 3'd0, 8'h10, 3'd2, 32'h0, 1'b0);
    chk("R10 held ip", ip, 32'h0000_0200);

    // halt: parks on itself, sticky, later steps ignored
    run_op("R9 halt", 3'd6, 3'd7, 8'h40, 3'd1, 32'h0, 1'b1);
    chk("R9 halt ip", ip, 32'h0000_0200);
    chk("R9 halted", {31'd0, halted}, 32'd1);
    run_op("R9 jump after halt", 3'd1, 3'd0, 8'h40, 3'd2, 32'h0, 1'b1);
    run_op("R9 reg after halt", 3'd5, 3'd0, 8'h00, 3'd2, 32'h1234, 1'b1);
    chk("R9 frozen ip", ip, 32'h0000_0200);

    // reset clears halt
    do_reset();
    @(negedge clk); #1;
    chk("R1 reset after halt ip", ip, 32'd0);
    chk("R1 reset after halt halted", {31'd0, halted}, 32'd0);
    run_op("R8 after reset", 3'd0, 3'd0, 8'd0, 3'd5, 32'd0, 1'b1);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule